// File: doc/BRIEF.md
# Quadrature Encoder Interface

This block decodes the two phase signals and the index signal of a rotary encoder. It keeps a position count and a direction flag. It also measures speed by counting valid edges over a programmable timer window. Four interrupt sources are raised: an index pulse, the end of a velocity window, a reversal of direction, and an illegal phase transition. All three encoder inputs pass through a synchronizer of `SYNC_STAGES` flops before they are used. Every transition of either phase moves the count by one, which is 4x decoding.

Software configures the block and reads it through a flat register port. A write strobe with an address and data takes effect on the next clock edge. The read port is combinational: `rd_data` follows `rd_addr` in the same cycle. The register map is:

| Address | Register | Access | Reset value |
|---|---|---|---|
| 0 | control: bit0 = enable, bit1 = clear position on index | RW | 0 |
| 1 | position limit | RW | all ones |
| 2 | position | RW (a write loads the counter) | 0 |
| 3 | timer reload | RW | all ones |
| 4 | captured velocity | RO | 0 |
| 5 | interrupt status: bit0 = index, bit1 = timer, bit2 = direction change, bit3 = phase error | write 1 to clear | 0 |
| 6 | interrupt mask (same bit layout as status) | RW | 0 |
| 7 | direction (bit0) | RO | 1 |

The position, the direction and the captured velocity are also available as plain output pins. The interface carries no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `qei_core`

## Requirements
- R1: The phase state is written AB, with A in the upper bit. The forward order is 00, 10, 11, 01, 00. A single-phase change that follows this order adds one to the position, and a change against it subtracts one. The position pin changes on the third rising clock edge after the input changes.
- R2: If both phases change between two synchronized samples, status bit3 is set. The position and the direction stay as they were.
- R3: The position stays in the range 0 to the limit register. Counting up from the limit gives 0, and counting down from 0 gives the limit.
- R4: The direction output is 1 after reset. Each counted edge sets it to 1 for forward and 0 for reverse. A counted edge whose direction differs from the stored direction sets status bit2.
- R5: A synchronized rising edge on the index input sets status bit0. If control bit1 is set, the same edge also sets the position to 0. If control bit1 is clear, the position is left unchanged.
- R6: The velocity timer counts down from the reload value, so its window is reload+1 cycles. When the window ends, the number of edges counted in it is copied to the velocity register, the edge counter is cleared, the timer is reloaded, and status bit1 is set.
- R7: The phases may change state on every clock cycle (each phase toggling at a quarter of the clock rate). Every change is counted.
- R8: Status bits stay set until a 1 is written to them. Writing 1 clears only that bit. If a bit is set and cleared in the same cycle, the set wins.
- R9: The irq output is high exactly when some status bit and its mask bit are both 1.
- R10: While control bit0 is 0, phase edges and index edges change nothing, the timer holds the reload value and the edge counter holds 0. Setting bit0 again does not produce a count from phase levels that are already present.
- R11: After reset, the registers read their listed reset values. A write to the position register loads the position on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| ph_idx | input | 1 | Encoder index, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| position | output | POS_W | Current position |
| dir | output | 1 | 1 = forward, 0 = reverse |
| velocity | output | VEL_W | Last captured edge count |
| irq | output | 1 | Masked interrupt request |

## Verification
Each phase or index change reaches the position, the direction and the status register on the third rising edge after it is driven: two flops for synchronization and one for the update. The bench therefore drives inputs on a falling edge, waits four rising edges and samples on the next falling edge. Register writes take effect on the edge inside the write task and are read back combinationally half a cycle later. Velocity results are due only at a window end, so the bench polls the timer status bit and checks the captured count and the spacing between two expiries, measured in cycles.

// File: rtl/qei_pkg.sv
package qei_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LIMIT = 3'd1;
  localparam logic [2:0] A_POS   = 3'd2;
  localparam logic [2:0] A_TLOAD = 3'd3;
  localparam logic [2:0] A_VCAP  = 3'd4;
  localparam logic [2:0] A_ISTAT = 3'd5;
  localparam logic [2:0] A_IMASK = 3'd6;
  localparam logic [2:0] A_DIR   = 3'd7;

  localparam int N_IRQ = 4;
  localparam int S_IDX = 0;
  localparam int S_TMR = 1;
  localparam int S_DIR = 2;
  localparam int S_ERR = 3;
endpackage

// File: rtl/qei_sync.sv
module qei_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '0;
        else        st[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[s] <= '0;
        else        st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/qei_decode.sv
module qei_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  input  logic idx_i,
  output logic step_o,
  output logic up_o,
  output logic err_o,
  output logic idx_rise_o
);
  logic a_q, b_q, idx_q;
  logic [1:0] chg;

  // Previous levels are tracked even while disabled, so re-enabling never
  // sees a stale difference.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q <= 1'b0; b_q <= 1'b0; idx_q <= 1'b0;
    end else begin
      a_q <= a_i; b_q <= b_i; idx_q <= idx_i;
    end

  assign chg        = {a_i ^ a_q, b_i ^ b_q};
  assign step_o     = en_i & (^chg);
  assign err_o      = en_i & (&chg);
  assign up_o       = b_q ^ a_i;
  assign idx_rise_o = en_i & idx_i & ~idx_q;
endmodule

// File: rtl/qei_position.sv
module qei_position #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         err_i,
  input  logic         idx_clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (ld_i)           pos_d = ld_val_i;
    else if (idx_clr_i) pos_d = '0;
    else if (step_i) begin
      if (up_i) pos_d = (pos_q >= max_i) ? '0 : pos_q + 1'b1;
      else      pos_d = (pos_q == '0) ? max_i : pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;

  assign pos_o = pos_q;

  a_r2_err_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !ld_i && !idx_clr_i) |=> $stable(pos_q));

  a_r3_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && up_i && !ld_i && !idx_clr_i && pos_q == max_i) |=> (pos_q == '0));

  a_r3_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !up_i && !ld_i && !idx_clr_i && pos_q == '0) |=> (pos_q == $past(max_i)));
endmodule

// File: rtl/qei_velocity.sv
module qei_velocity #(
  parameter int TW = 16,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          edge_i,
  input  logic [TW-1:0] load_i,
  output logic [VW-1:0] cap_o,
  output logic          expire_o
);
  logic [TW-1:0] tmr_q;
  logic [VW-1:0] cnt_q, cap_q, cnt_inc;

  assign cnt_inc  = (edge_i && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
  assign expire_o = en_i && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr_q <= '1;
      cnt_q <= '0;
      cap_q <= '0;
    end else if (!en_i) begin
      tmr_q <= load_i;
      cnt_q <= '0;
    end else if (tmr_q == '0) begin
      tmr_q <= load_i;
      cnt_q <= '0;
      cap_q <= cnt_inc;
    end else begin
      tmr_q <= tmr_q - 1'b1;
      cnt_q <= cnt_inc;
    end

  assign cap_o = cap_q;

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (tmr_q == $past(load_i) && cnt_q == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/qei_core.sv
module qei_core
  import qei_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int VEL_W       = 16,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic             ph_idx,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [POS_W-1:0] position,
  output logic             dir,
  output logic [VEL_W-1:0] velocity,
  output logic             irq
);
  logic [1:0]       ctrl_q;
  logic [POS_W-1:0] limit_q;
  logic [TMR_W-1:0] tload_q;
  logic [N_IRQ-1:0] mask_q, stat_q, stat_set, stat_clr;
  logic             dir_q;

  logic [2:0] syn;
  logic step, up, perr, idx_rise, expire, pos_ld, stat_wr;

  qei_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({ph_a, ph_b, ph_idx}), .q_o(syn)
  );

  qei_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[0]),
    .a_i(syn[2]), .b_i(syn[1]), .idx_i(syn[0]),
    .step_o(step), .up_o(up), .err_o(perr), .idx_rise_o(idx_rise)
  );

  assign pos_ld = wr_en && (wr_addr == A_POS);

  qei_position #(.W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_i(step), .up_i(up), .err_i(perr),
    .idx_clr_i(idx_rise && ctrl_q[1]), .ld_i(pos_ld),
    .ld_val_i(wr_data[POS_W-1:0]), .max_i(limit_q), .pos_o(position)
  );

  qei_velocity #(.TW(TMR_W), .VW(VEL_W)) u_vel (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[0]), .edge_i(step),
    .load_i(tload_q), .cap_o(velocity), .expire_o(expire)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '1;
      tload_q <= '1;
      mask_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl_q  <= wr_data[1:0];
        A_LIMIT: limit_q <= wr_data[POS_W-1:0];
        A_TLOAD: tload_q <= wr_data[TMR_W-1:0];
        A_IMASK: mask_q  <= wr_data[N_IRQ-1:0];
        default: ;
      endcase
    end

  // Direction tracking
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dir_q <= 1'b1;
    else if (step) dir_q <= up;

  // Sticky status, write-one-to-clear, set has priority
  always_comb begin
    stat_set        = '0;
    stat_set[S_IDX] = idx_rise;
    stat_set[S_TMR] = expire;
    stat_set[S_DIR] = step && (up != dir_q);
    stat_set[S_ERR] = perr;
  end

  assign stat_wr  = wr_en && (wr_addr == A_ISTAT);
  assign stat_clr = stat_wr ? wr_data[N_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | stat_set;

  assign irq = |(stat_q & mask_q);
  assign dir = dir_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[1:0]       = ctrl_q;
      A_LIMIT: rd_data[POS_W-1:0] = limit_q;
      A_POS:   rd_data[POS_W-1:0] = position;
      A_TLOAD: rd_data[TMR_W-1:0] = tload_q;
      A_VCAP:  rd_data[VEL_W-1:0] = velocity;
      A_ISTAT: rd_data[N_IRQ-1:0] = stat_q;
      A_IMASK: rd_data[N_IRQ-1:0] = mask_q;
      default: rd_data[0]         = dir_q;
    endcase
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r4_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (dir_q == $past(up)));

  a_r2_err_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> $stable(dir_q));

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/tb_qei_core.sv
module tb_qei_core;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph_a = 1'b0, ph_b = 1'b0, ph_idx = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [15:0] position, velocity;
  logic dir, irq;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [1:0] ab = 2'b00;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  qei_core dut (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .ph_idx(ph_idx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .position(position), .dir(dir), .velocity(velocity), .irq(irq)
  );

  // {ab, expected position, expected dir}, limit = 5, start at AB=00
  localparam logic [6:0] VEC [11] = '{
    {2'b10, 4'd1, 1'b1}, {2'b11, 4'd2, 1'b1}, {2'b01, 4'd3, 1'b1},
    {2'b00, 4'd4, 1'b1}, {2'b10, 4'd5, 1'b1}, {2'b11, 4'd0, 1'b1},
    {2'b10, 4'd5, 1'b0}, {2'b00, 4'd4, 1'b0}, {2'b11, 4'd4, 1'b0},
    {2'b01, 4'd5, 1'b1}, {2'b00, 4'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_ab(input logic [1:0] v);
    @(negedge clk);
    ab = v; ph_a = v[1]; ph_b = v[0];
    settle();
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic wait_timer(output int t, output logic ok);
    logic [31:0] s;
    ok = 1'b0; t = 0;
    for (int i = 0; i < 400; i++) begin
      rd(3'd5, s);
      if (s[1]) begin ok = 1'b1; t = cyc; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int t1, t2;
    logic ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset values
    chk("R11 position", {16'd0, position}, 0);
    chk("R4 dir after reset", {31'd0, dir}, 1);
    chk("R9 irq after reset", {31'd0, irq}, 0);
    rd(3'd1, r); chk("R11 limit reset", r, 32'hFFFF);
    rd(3'd3, r); chk("R11 tload reset", r, 32'hFFFF);
    rd(3'd0, r); chk("R11 ctrl reset", r, 0);
    rd(3'd5, r); chk("R11 status reset", r, 0);

    wr(3'd1, 5);
    wr(3'd0, 1);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 11; i++) begin
      drive_ab(VEC[i][6:5]);
      chk("R1/R3 position", {16'd0, position}, {28'd0, VEC[i][4:1]});
      chk("R4/R2 dir", {31'd0, dir}, {31'd0, VEC[i][0]});
    end

    // R2 R4: error and direction change status
    rd(3'd5, r); chk("R2 R4 status", r, 32'hC);

    // R9 masking, R8 partial W1C
    chk("R9 irq masked off", {31'd0, irq}, 0);
    wr(3'd6, 32'h8);
    chk("R9 irq unmasked", {31'd0, irq}, 1);
    wr(3'd5, 32'h4);
    rd(3'd5, r); chk("R8 partial clear", r, 32'h8);
    chk("R9 irq still", {31'd0, irq}, 1);
    wr(3'd5, 32'h8);
    rd(3'd5, r); chk("R8 cleared", r, 0);
    chk("R9 irq cleared", {31'd0, irq}, 0);

    // R10: disabled ignores edges, no spurious count on re-enable
    wr(3'd0, 0);
    drive_ab(fwd(ab));
    chk("R10 disabled no count", {16'd0, position}, 0);
    wr(3'd0, 1);
    settle();
    chk("R10 no spurious count", {16'd0, position}, 0);
    rd(3'd5, r); chk("R10 no status", r, 0);
    drive_ab(fwd(ab));
    chk("R1 count after enable", {16'd0, position}, 1);

    // R11: position load
    wr(3'd2, 3);
    chk("R11 position load", {16'd0, position}, 3);

    // R5: index without clear
    @(negedge clk); ph_idx = 1'b1;
    repeat (3) @(negedge clk); ph_idx = 1'b0;
    settle();
    chk("R5 index keeps position", {16'd0, position}, 3);
    rd(3'd5, r); chk("R5 index status", r, 32'h1);
    wr(3'd5, 32'h1);

    // R5: index with clear
    wr(3'd0, 3);
    @(negedge clk); ph_idx = 1'b1;
    repeat (3) @(negedge clk); ph_idx = 1'b0;
    settle();
    chk("R5 index clears position", {16'd0, position}, 0);
    wr(3'd0, 1);
    wr(3'd5, 32'hF);

    // R6 R7: full-rate edges and velocity window
    wr(3'd1, 1000);
    wr(3'd0, 0);
    wr(3'd3, 99);
    wr(3'd5, 32'hF);
    wr(3'd0, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ab = fwd(ab); ph_a = ab[1]; ph_b = ab[0];
    end
    settle();
    chk("R7 full-rate count", {16'd0, position}, 8);
    wait_timer(t1, ok);
    chk("R6 first expiry seen", {31'd0, ok}, 1);
    chk("R6 captured edges", {16'd0, velocity}, 8);
    wr(3'd5, 32'h2);
    wait_timer(t2, ok);
    chk("R6 second expiry seen", {31'd0, ok}, 1);
    chk("R6 window length", t2 - t1, 100);
    chk("R6 empty window", {16'd0, velocity}, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule